// File: doc/BRIEF.md
# Dual-Channel Sleep and Wake Controller

This block decides when a two-channel serial port device may stop its crystal oscillator, and when it must start it again. It watches each channel's pair of sleep-permission bits, each channel's pending-interrupt flag, the receive data lines, the four active-low modem status inputs per channel, the transmit-holding write strobes and the modem-status read strobes. From these it drives one oscillator enable and one sleep status flag.

Sleep is entered only after every permission bit is set, no interrupt is pending, no modem change is left unacknowledged and no line activity has been seen for a programmable number of quiet cycles. While asleep, the synchronous state is frozen. A wake source is compared against the frozen state combinationally, so the oscillator enable rises in the same cycle as the wake event, before any register samples it. Once every condition has been serviced, the block returns to sleep by itself after the same quiet window.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: During and right after reset, `asleep` is 0 and `osc_en` is 1.
- R2: With all conditions quiet, `asleep` rises on the (SETTLE_CYC+1)-th rising clock edge after quiet begins. It is still 0 after SETTLE_CYC edges. While asleep with no wake source, `osc_en` is 0.
- R3: Clearing any bit of `slp_perm_a` or `slp_perm_b` on any channel raises `osc_en` in the same cycle and clears `asleep` at the next edge.
- R4: A set bit of `irq_pend` raises `osc_en` in the same cycle, clears `asleep` at the next edge, and holds the device awake for as long as it stays set.
- R5: A 1-to-0 transition on any channel's `rxd`, relative to the level last sampled while awake, raises `osc_en` in the same cycle and clears `asleep` at the next edge. A line that was already low before sleep, and stays low, does not wake the device. A 0-to-1 transition does not wake it either.
- R6: Any change of any bit of `modem_n` (CH*MODEM_W+bit, bits 0..3 per channel) wakes the device in the same way. The change is latched as pending and keeps the device awake until that channel's `msr_rd` strobe is seen.
- R7: A `thr_wr` strobe on either channel wakes the device in the same way.
- R8: After any wake, once all conditions have cleared, the device re-enters sleep with the timing of R2.
- R9: A `msr_rd` strobe on one channel does not clear a pending modem change on the other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock (always-on domain) |
| rst_n | input | 1 | Active-low asynchronous reset |
| slp_perm_a | input | NUM_CH | First sleep-permission bit per channel |
| slp_perm_b | input | NUM_CH | Second sleep-permission bit per channel |
| irq_pend | input | NUM_CH | Pending-interrupt flag per channel |
| rxd | input | NUM_CH | Receive data line per channel, idles high |
| modem_n | input | NUM_CH*MODEM_W | Active-low modem status inputs, channel-major |
| thr_wr | input | NUM_CH | Transmit holding register write strobe per channel |
| msr_rd | input | NUM_CH | Modem status register read strobe per channel |
| osc_en | output | 1 | Oscillator enable; low only while asleep and no wake source present |
| asleep | output | 1 | Sleep status |

## Verification
The assertions assume that inputs change only between clock edges. They also assume that the modem inputs come out of reset at their inactive (all ones) level, because the reset value of the captured modem state is that level. The bench drives every input on the falling clock edge. It starts with all modem lines high and `rxd` idle high, and it only leaves a modem line changed when the test acknowledges that change through `msr_rd`.

// File: rtl/swk_pkg.sv
package swk_pkg;

   typedef struct packed {
      logic wake;   // wake source against frozen state
      logic busy;   // line activity seen while awake
      logic hold;   // condition that blocks sleep
   } swk_ch_stat_t;

endpackage

// File: rtl/swk_chan_mon.sv
module swk_chan_mon
   import swk_pkg::*;
#(
   parameter int MODEM_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic               rxd,
   input  logic [MODEM_W-1:0] modem_n,
   input  logic               thr_wr,
   input  logic               msr_rd,
   input  logic               irq_pend,
   output swk_ch_stat_t       stat
);

   logic               rx_prev;
   logic [MODEM_W-1:0] modem_prev;
   logic               delta_pend;
   logic               rx_fall;
   logic               modem_chg;

   assign rx_fall   = rx_prev & ~rxd;
   assign modem_chg = |(modem_n ^ modem_prev);

   // Sampled state only advances while the oscillator runs
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_prev    <= 1'b1;
         modem_prev <= '1;
      end else if (run) begin
         rx_prev    <= rxd;
         modem_prev <= modem_n;
      end
   end

   // Modem change latch: set has priority over acknowledge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         delta_pend <= 1'b0;
      else
         delta_pend <= (delta_pend & ~msr_rd) | (run & modem_chg);
   end

   always_comb begin
      stat.wake = rx_fall | modem_chg | thr_wr | irq_pend;
      stat.busy = run & (rx_fall | modem_chg | thr_wr);
      stat.hold = irq_pend | delta_pend;
   end

   AST_DELTA_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      run && modem_chg |=> delta_pend) else $error("delta not latched"); // R6
   AST_DELTA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      delta_pend && !msr_rd |=> delta_pend) else $error("delta lost"); // R9

endmodule

// File: rtl/swk_quiet_timer.sv
module swk_quiet_timer #(
   parameter int SETTLE_CYC = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic quiet,
   output logic ready
);

   generate
      if (SETTLE_CYC == 0) begin : g_immediate
         assign ready = quiet & ~clear;
      end else begin : g_count
         localparam int CNT_W = $clog2(SETTLE_CYC + 1);
         localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SETTLE_CYC);
         logic [CNT_W-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt <= '0;
            else if (clear || !quiet)
               cnt <= '0;
            else if (cnt != CNT_MAX)
               cnt <= cnt + 1'b1;
         end

         assign ready = quiet & ~clear & (cnt == CNT_MAX);

         AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            cnt <= CNT_MAX) else $error("counter overrun"); // R8
         AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
            !quiet |=> cnt == '0) else $error("counter not restarted"); // R2
      end
   endgenerate

endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
   import swk_pkg::*;
#(
   parameter int NUM_CH     = 2,
   parameter int MODEM_W    = 4,
   parameter int SETTLE_CYC = 6
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_CH-1:0]         slp_perm_a,
   input  logic [NUM_CH-1:0]         slp_perm_b,
   input  logic [NUM_CH-1:0]         irq_pend,
   input  logic [NUM_CH-1:0]         rxd,
   input  logic [NUM_CH*MODEM_W-1:0] modem_n,
   input  logic [NUM_CH-1:0]         thr_wr,
   input  logic [NUM_CH-1:0]         msr_rd,
   output logic                      osc_en,
   output logic                      asleep
);

   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("NUM_CH must be at least 1");
      end
      if (MODEM_W < 1) begin : g_bad_mw
         $error("MODEM_W must be at least 1");
      end
      if (SETTLE_CYC < 0) begin : g_bad_settle
         $error("SETTLE_CYC must not be negative");
      end
   endgenerate

   logic              asleep_q;
   logic              run;
   logic              cfg_ok;
   logic              wake_any;
   logic              quiet;
   logic              ready;
   logic [NUM_CH-1:0] wake_v;
   logic [NUM_CH-1:0] busy_v;
   logic [NUM_CH-1:0] hold_v;

   assign run = ~asleep_q;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      swk_ch_stat_t st;
      swk_chan_mon #(.MODEM_W(MODEM_W)) u_mon (
         .clk      (clk),
         .rst_n    (rst_n),
         .run      (run),
         .rxd      (rxd[c]),
         .modem_n  (modem_n[c*MODEM_W +: MODEM_W]),
         .thr_wr   (thr_wr[c]),
         .msr_rd   (msr_rd[c]),
         .irq_pend (irq_pend[c]),
         .stat     (st)
      );
      assign wake_v[c] = st.wake;
      assign busy_v[c] = st.busy;
      assign hold_v[c] = st.hold;
   end

   assign cfg_ok   = (&slp_perm_a) & (&slp_perm_b);
   assign wake_any = ~cfg_ok | (|wake_v);
   assign quiet    = cfg_ok & ~(|hold_v) & ~(|busy_v);

   swk_quiet_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (asleep_q),
      .quiet (quiet),
      .ready (ready)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         asleep_q <= 1'b0;
      else if (asleep_q)
         asleep_q <= ~wake_any;
      else
         asleep_q <= ready;
   end

   // Oscillator restarts combinationally on any wake source
   assign osc_en = ~asleep_q | wake_any;
   assign asleep = asleep_q;

   AST_ENTER_PERMITTED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(asleep_q) |-> $past(cfg_ok && !(|irq_pend))) else $error("bad entry"); // R3
   AST_WAKE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      asleep_q && wake_any |=> !asleep_q) else $error("wake ignored"); // R5
   AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      asleep_q && !wake_any |=> asleep_q) else $error("spurious exit"); // R2
   AST_IRQ_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_pend) |=> !asleep_q) else $error("slept with irq"); // R4

endmodule

// File: tb/sleep_wake_ctrl_test.sv
module sleep_wake_ctrl_test;

   localparam int CLK_PERIOD = 10;
   localparam int NUM_CH     = 2;
   localparam int MODEM_W    = 4;
   localparam int SETTLE_CYC = 6;

   logic                      clk = 1'b0;
   logic                      rst_n = 1'b0;
   logic [NUM_CH-1:0]         slp_perm_a = '1;
   logic [NUM_CH-1:0]         slp_perm_b = '1;
   logic [NUM_CH-1:0]         irq_pend = '0;
   logic [NUM_CH-1:0]         rxd = '1;
   logic [NUM_CH*MODEM_W-1:0] modem_n = '1;
   logic [NUM_CH-1:0]         thr_wr = '0;
   logic [NUM_CH-1:0]         msr_rd = '0;
   logic                      osc_en;
   logic                      asleep;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sleep_wake_ctrl #(.NUM_CH(NUM_CH), .MODEM_W(MODEM_W), .SETTLE_CYC(SETTLE_CYC)) uut (
      .clk(clk), .rst_n(rst_n), .slp_perm_a(slp_perm_a), .slp_perm_b(slp_perm_b),
      .irq_pend(irq_pend), .rxd(rxd), .modem_n(modem_n), .thr_wr(thr_wr),
      .msr_rd(msr_rd), .osc_en(osc_en), .asleep(asleep)
   );

   task automatic chk(input string req, input logic act, input logic exp, input string what);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
      end
   endtask

   // Called at a falling edge where every condition is already quiet
   task automatic expect_reentry(input string req);
      repeat (SETTLE_CYC) @(posedge clk);
      @(negedge clk);
      chk(req, asleep, 1'b0, "asleep before window");
      chk(req, osc_en, 1'b1, "osc_en before window");
      @(posedge clk);
      @(negedge clk);
      chk(req, asleep, 1'b1, "asleep after window");
      chk(req, osc_en, 1'b0, "osc_en after window");
   endtask

   // Stimulus already driven at this falling edge
   task automatic expect_wake(input string req);
      #1;
      chk(req, osc_en, 1'b1, "osc_en same cycle");
      @(negedge clk);
      chk(req, asleep, 1'b0, "asleep after wake edge");
   endtask

   task automatic wake_case(input int ch, input int src);
      @(negedge clk);
      case (src)
         0: begin rxd[ch] = 1'b0; expect_wake("R5"); rxd[ch] = 1'b1; expect_reentry("R8"); end
         1: begin thr_wr[ch] = 1'b1; expect_wake("R7"); thr_wr[ch] = 1'b0; expect_reentry("R8"); end
         2: begin
            irq_pend[ch] = 1'b1; expect_wake("R4");
            repeat (SETTLE_CYC + 3) @(negedge clk);
            chk("R4", asleep, 1'b0, "held awake by irq");
            irq_pend[ch] = 1'b0; expect_reentry("R8");
         end
         3: begin slp_perm_a[ch] = 1'b0; expect_wake("R3"); slp_perm_a[ch] = 1'b1; expect_reentry("R8"); end
         4: begin slp_perm_b[ch] = 1'b0; expect_wake("R3"); slp_perm_b[ch] = 1'b1; expect_reentry("R8"); end
         default: begin
            modem_n[ch*MODEM_W + (src-5)] = ~modem_n[ch*MODEM_W + (src-5)];
            expect_wake("R6");
            repeat (3*SETTLE_CYC) @(negedge clk);
            chk("R6", asleep, 1'b0, "held awake by modem change");
            msr_rd[1-ch] = 1'b1;
            @(negedge clk);
            msr_rd[1-ch] = 1'b0;
            repeat (SETTLE_CYC + 2) @(negedge clk);
            chk("R9", asleep, 1'b0, "other channel read kept change");
            msr_rd[ch] = 1'b1;
            @(negedge clk);
            msr_rd[ch] = 1'b0;
            expect_reentry("R6");
         end
      endcase
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", asleep, 1'b0, "asleep in reset");
      chk("R1", osc_en, 1'b1, "osc_en in reset");
      rst_n = 1'b1;
      chk("R1", asleep, 1'b0, "asleep after reset");
      expect_reentry("R2");
      repeat (4) @(negedge clk);
      chk("R2", asleep, 1'b1, "stays asleep");
      chk("R2", osc_en, 1'b0, "osc stays off");
      for (int ch = 0; ch < NUM_CH; ch++)
         for (int src = 0; src < 5 + MODEM_W; src++)
            wake_case(ch, src);
      // Low line held across sleep is not a start bit
      @(negedge clk);
      rxd[0] = 1'b0;
      expect_wake("R5");
      @(negedge clk);
      expect_reentry("R5");
      repeat (5) @(negedge clk);
      chk("R5", asleep, 1'b1, "steady low line ignored");
      chk("R5", osc_en, 1'b0, "steady low osc");
      rxd[0] = 1'b1;
      #1;
      chk("R5", osc_en, 1'b0, "rising edge no wake");
      @(negedge clk);
      chk("R5", asleep, 1'b1, "rising edge no exit");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule